// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block takes the interrupt sources of one processor and turns them into a single request toward the core. It keeps a vector of external request lines, one per priority level. Each line is set and cleared by separate raise and lower events. The resolver merges this vector with a software-interrupt word to form a pending-level vector. Two bits of the software word are timer-match flags, and both of them map onto a fixed level 14.

Each clock, the resolver compares the pending levels with the core's current priority level. Only a level strictly above the current priority can be chosen, and the highest such level wins. The chosen level is turned into a trap code. A new request is held back while a trap of a higher type is already running at a nonzero trap level. Dropping the global enable, or losing every eligible level, withdraws the request and zeroes the code. Both outputs come straight from flops.

Top module: `pil_resolver`

## Requirements
- R1: A raise event on external line n sets bit n of the held request vector, and a lower event clears it. When both events occur in the same cycle, the raise wins. A held-vector change reaches the outputs one clock after the vector itself updates.
- R2: The pending vector is the OR of the held external vector and bits 1 to 15 of the software word. Software bit n stands for level n.
- R3: Software bit 0 (tick match) and bit 16 (system-tick match) do not request their own level. If either of them is set, level 14 is pending.
- R4: Only levels strictly greater than `cur_pil` are eligible, and the highest eligible pending level is selected.
- R5: The trap code for level L is 9'h040 OR L, so valid codes run from 0x041 to 0x04F.
- R6: If no pending level exceeds `cur_pil` (the pending vector is below 2 shifted left by `cur_pil`), an asserted request is dropped and the code becomes 0. This holds whatever the enable is.
- R7: If `trap_lvl` is nonzero and `tt_active` is greater than the candidate code, the outputs keep their previous values. An equal trap type does not block.
- R8: The outputs change to a new request only when the candidate code differs from the stored code. Otherwise they stay stable.
- R9: While `int_en` is low and an eligible level exists, an outstanding request is cleared and the code becomes 0. No new request is raised.
- R10: Reset forces `irq_req` to 0 and `irq_code` to 0.
- R11: Both outputs are registered. A change on `soft_vec`, `cur_pil`, `int_en`, `trap_lvl` or `tt_active` shows at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_raise | input | 16 | Per-level raise events for the external lines |
| ext_lower | input | 16 | Per-level lower events for the external lines |
| soft_vec | input | 17 | Software-interrupt word; bits 0 and 16 are timer-match flags |
| cur_pil | input | 4 | Current processor priority level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| tt_active | input | 9 | Trap type currently in progress |
| irq_req | output | 1 | Registered interrupt request |
| irq_code | output | 9 | Trap code of the selected level, 0 when idle |

## Verification
A corrupted held line vector does not show at once. It appears as a wrong code or a missing request one clock after the vector is written, and only when the affected level is above the current priority. A fault in the stored code or request flop shows in the same cycle it happens. It can also persist silently while a higher trap type blocks updates. The bench therefore compares both outputs against a model on every cycle, so a divergence is reported within one clock of becoming observable.

// File: rtl/pil_pkg.sv
package pil_pkg;
  localparam int unsigned NUM_LVL   = 16;
  localparam int unsigned LVL_W     = $clog2(NUM_LVL);
  localparam int unsigned SOFT_W    = NUM_LVL + 1;
  localparam int unsigned TT_W      = 9;
  localparam int unsigned TL_W      = 3;
  localparam int unsigned TICK_BIT  = 0;
  localparam int unsigned STICK_BIT = NUM_LVL;
  localparam int unsigned TIMER_LVL = 14;
  localparam logic [TT_W-1:0] TRAP_BASE = 9'h040;
endpackage

// File: rtl/pil_line_reg.sv
module pil_line_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] lower,
  output logic [N-1:0] vec
);
  logic [N-1:0] vec_nx;
  logic         vec_en;

  always_comb begin
    vec_nx = (vec & ~lower) | raise;
    vec_en = (vec_nx != vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec <= '0;
    end else if (vec_en) begin
      vec <= vec_nx;
    end
  end
endmodule

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
  parameter int unsigned N         = 16,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned TICK_BIT  = 0,
  parameter int unsigned STICK_BIT = 16,
  parameter int unsigned TIMER_LVL = 14
) (
  input  logic [N-1:0]      ext_vec,
  input  logic [SOFT_W-1:0] soft_vec,
  output logic [N-1:0]      pend
);
  logic [SOFT_W-1:0] soft_lvls;
  logic              timer_hit;

  always_comb begin
    soft_lvls            = soft_vec;
    soft_lvls[TICK_BIT]  = 1'b0;
    soft_lvls[STICK_BIT] = 1'b0;
    timer_hit            = soft_vec[TICK_BIT] | soft_vec[STICK_BIT];
  end

  for (genvar g = 0; g < N; g++) begin : g_lvl
    if (g == TIMER_LVL) begin : g_tmr
      assign pend[g] = ext_vec[g] | soft_lvls[g] | timer_hit;
    end else begin : g_pln
      assign pend[g] = ext_vec[g] | soft_lvls[g];
    end
  end
endmodule

// File: rtl/pil_prio_pick.sv
module pil_prio_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned LVL_W = 4
) (
  input  logic [N-1:0]     pend,
  input  logic [LVL_W-1:0] cur_pil,
  output logic             vld,
  output logic [LVL_W-1:0] lvl
);
  logic [N-1:0] elig;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = pend[g] && (LVL_W'(g) > cur_pil);
  end

  always_comb begin
    vld = 1'b0;
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i]) begin
        vld = 1'b1;
        lvl = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pil_resolver.sv
module pil_resolver
  import pil_pkg::*;
#(
  parameter int unsigned NLVL  = NUM_LVL,
  parameter int unsigned LW    = LVL_W,
  parameter int unsigned SW    = SOFT_W,
  parameter int unsigned TW    = TT_W,
  parameter int unsigned TLW   = TL_W,
  parameter logic [TW-1:0] BASE = TRAP_BASE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NLVL-1:0] ext_raise,
  input  logic [NLVL-1:0] ext_lower,
  input  logic [SW-1:0]  soft_vec,
  input  logic [LW-1:0]  cur_pil,
  input  logic           int_en,
  input  logic [TLW-1:0] trap_lvl,
  input  logic [TW-1:0]  tt_active,
  output logic           irq_req,
  output logic [TW-1:0]  irq_code
);
  localparam int unsigned PADW = TW - LW;

  logic [NLVL-1:0] ext_vec;
  logic [NLVL-1:0] pend;
  logic            pick_vld;
  logic [LW-1:0]   pick_lvl;
  logic [TW-1:0]   cand;
  logic            blocked;
  logic            req_nx;
  logic [TW-1:0]   code_nx;
  logic            out_en;

  pil_line_reg #(.N(NLVL)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (ext_raise),
    .lower (ext_lower),
    .vec   (ext_vec)
  );

  pil_pend_merge #(
    .N(NLVL), .SOFT_W(SW), .TICK_BIT(TICK_BIT),
    .STICK_BIT(STICK_BIT), .TIMER_LVL(TIMER_LVL)
  ) u_merge (
    .ext_vec  (ext_vec),
    .soft_vec (soft_vec),
    .pend     (pend)
  );

  pil_prio_pick #(.N(NLVL), .LVL_W(LW)) u_pick (
    .pend    (pend),
    .cur_pil (cur_pil),
    .vld     (pick_vld),
    .lvl     (pick_lvl)
  );

  always_comb begin
    cand    = BASE | {{PADW{1'b0}}, pick_lvl};
    blocked = (trap_lvl != '0) && (tt_active > cand);
    req_nx  = irq_req;
    code_nx = irq_code;
    if (!pick_vld) begin
      if (irq_req) begin
        req_nx  = 1'b0;
        code_nx = '0;
      end
    end else if (int_en) begin
      if (!blocked && (irq_code != cand)) begin
        req_nx  = 1'b1;
        code_nx = cand;
      end
    end else if (irq_req) begin
      req_nx  = 1'b0;
      code_nx = '0;
    end
    out_en = (req_nx != irq_req) || (code_nx != irq_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_code <= '0;
    end else if (out_en) begin
      irq_req  <= req_nx;
      irq_code <= code_nx;
    end
  end
endmodule

// File: rtl/pil_resolver_chk.sv
module pil_resolver_chk #(
  parameter int unsigned NLVL     = 16,
  parameter int unsigned LW       = 4,
  parameter int unsigned SW       = 17,
  parameter int unsigned TW       = 9,
  parameter int unsigned TLW      = 3,
  parameter int unsigned TICK_IDX = 0,
  parameter logic [TW-1:0] BASE   = 9'h040
) (
  input logic           clk,
  input logic           rst_n,
  input logic [SW-1:0]  soft_vec,
  input logic [LW-1:0]  cur_pil,
  input logic           int_en,
  input logic [TLW-1:0] trap_lvl,
  input logic [TW-1:0]  tt_active,
  input logic           irq_req,
  input logic [TW-1:0]  irq_code
);
  localparam logic [LW-1:0] TOP_PIL = LW'(NLVL - 1);

  // R9: disable withdraws an outstanding request
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && irq_req) |=> (!irq_req && irq_code == '0));

  // R6: nothing exceeds the top priority level
  a_r6_top_pil_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pil == TOP_PIL && irq_req) |=> (!irq_req && irq_code == '0));

  // R5: code carries the base and a nonzero level while requesting
  a_r5_code_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_code[TW-1:LW] == BASE[TW-1:LW] && irq_code[LW-1:0] != '0));

  // R7: a new request never undercuts a running higher trap type
  a_r7_no_undercut: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(trap_lvl) == '0 || $past(tt_active) <= irq_code));

  // R3: a timer flag raises at least level 14 when allowed
  a_r3_timer_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && soft_vec[TICK_IDX] && cur_pil < LW'(14) && trap_lvl == '0)
      |=> (irq_req && irq_code[LW-1:0] >= LW'(14)));
endmodule

bind pil_resolver pil_resolver_chk #(
  .NLVL(NLVL), .LW(LW), .SW(SW), .TW(TW), .TLW(TLW),
  .TICK_IDX(pil_pkg::TICK_BIT), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_vec  (soft_vec),
  .cur_pil   (cur_pil),
  .int_en    (int_en),
  .trap_lvl  (trap_lvl),
  .tt_active (tt_active),
  .irq_req   (irq_req),
  .irq_code  (irq_code)
);

// File: tb/sim_pil_resolver.sv
`timescale 1ns/1ps
module sim_pil_resolver;
  logic        clk;
  logic        rst_n;
  logic [15:0] ext_raise, ext_lower;
  logic [16:0] soft_vec;
  logic [3:0]  cur_pil;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  tt_active;
  logic        irq_req;
  logic [8:0]  irq_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [15:0] m_ext;
  logic        m_req;
  logic [8:0]  m_code;

  pil_resolver u0 (
    .clk(clk), .rst_n(rst_n), .ext_raise(ext_raise), .ext_lower(ext_lower),
    .soft_vec(soft_vec), .cur_pil(cur_pil), .int_en(int_en),
    .trap_lvl(trap_lvl), .tt_active(tt_active),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ext = '0; m_req = 1'b0; m_code = '0;
    end else begin
      logic [15:0] pend;
      logic [8:0]  nc;
      int          hi;
      pend = m_ext | (soft_vec[15:0] & 16'hFFFE);
      if (soft_vec[0] || soft_vec[16]) pend[14] = 1'b1;
      hi = -1;
      for (int i = 15; i >= 0; i--)
        if (hi < 0 && pend[i] && i > int'(cur_pil)) hi = i;
      if (hi < 0) begin
        if (m_req) begin m_req = 1'b0; m_code = '0; end
      end else if (int_en) begin
        nc = 9'h040 | 9'(hi);
        if (!(trap_lvl != 0 && tt_active > nc) && m_code != nc) begin
          m_req = 1'b1; m_code = nc;
        end
      end else if (m_req) begin
        m_req = 1'b0; m_code = '0;
      end
      m_ext = (m_ext & ~ext_lower) | ext_raise;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " model req"}, 32'(irq_req), 32'(m_req));
    chk({tag, " model code"}, 32'(irq_code), 32'(m_code));
  endtask

  task automatic expect_out(input string tag, input logic r, input logic [8:0] c);
    chk({tag, " req"}, 32'(irq_req), 32'(r));
    chk({tag, " code"}, 32'(irq_code), 32'(c));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ext_raise = '0; ext_lower = '0; soft_vec = '0;
    cur_pil = '0; int_en = 1'b1; trap_lvl = '0; tt_active = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_out("R10 reset", 1'b0, 9'h000);

    // R1 / R11: raise line 5, outputs follow one edge after the vector
    ext_raise = 16'h0020;
    cyc("R1");
    ext_raise = '0;
    expect_out("R11 latency", 1'b0, 9'h000);
    cyc("R1");
    expect_out("R1 R5 line5", 1'b1, 9'h045);

    // R4: higher line wins
    ext_raise = 16'h0200; cyc("R4"); ext_raise = '0; cyc("R4");
    expect_out("R4 highest", 1'b1, 9'h049);

    // R6 / R4 strictness
    cur_pil = 4'd9; cyc("R6");
    expect_out("R6 below thresh", 1'b0, 9'h000);
    cur_pil = 4'd8; cyc("R4");
    expect_out("R4 strictly above", 1'b1, 9'h049);

    // R1: lower clears
    cur_pil = 4'd0; ext_lower = 16'h0220; cyc("R1"); ext_lower = '0; cyc("R1");
    expect_out("R1 lower", 1'b0, 9'h000);

    // R3: timer flags on level 14
    soft_vec = 17'h00001; cur_pil = 4'd3; cyc("R3");
    expect_out("R3 tick", 1'b1, 9'h04E);
    soft_vec = 17'h10000; cyc("R3");
    expect_out("R3 stick", 1'b1, 9'h04E);
    cur_pil = 4'd14; cyc("R3");
    expect_out("R3 pil14", 1'b0, 9'h000);

    // R2: software level
    soft_vec = 17'h00080; cur_pil = 4'd0; cyc("R2");
    expect_out("R2 soft7", 1'b1, 9'h047);
    soft_vec = '0; cyc("R2");

    // R7: trap type blocking
    trap_lvl = 3'd1; tt_active = 9'h050; soft_vec = 17'h00008; cyc("R7");
    expect_out("R7 blocked", 1'b0, 9'h000);
    tt_active = 9'h043; cyc("R7");
    expect_out("R7 equal ok", 1'b1, 9'h043);
    soft_vec = 17'h00048; tt_active = 9'h050; cyc("R8");
    expect_out("R8 hold", 1'b1, 9'h043);
    trap_lvl = '0; cyc("R8");
    expect_out("R8 update", 1'b1, 9'h046);

    // R9: global disable
    int_en = 1'b0; cyc("R9");
    expect_out("R9 clear", 1'b0, 9'h000);
    cyc("R9");
    expect_out("R9 stays", 1'b0, 9'h000);
    int_en = 1'b1; cyc("R9");
    expect_out("R9 reenable", 1'b1, 9'h046);

    // R1: raise beats lower in the same cycle
    soft_vec = '0; ext_raise = 16'h1000; ext_lower = 16'h1000; cyc("R1");
    ext_raise = '0; ext_lower = '0; cyc("R1");
    expect_out("R1 raise wins", 1'b1, 9'h04C);
    ext_lower = 16'h1000; cyc("R1"); ext_lower = '0; cyc("R1");
    expect_out("R1 cleared", 1'b0, 9'h000);

    // R6: top priority masks everything
    soft_vec = 17'h1FFFF; cur_pil = 4'd15; cyc("R6");
    expect_out("R6 pil15", 1'b0, 9'h000);
    soft_vec = '0; cur_pil = 4'd0; cyc("R6");

    // random mix, compared against the model every cycle
    for (int k = 0; k < 4000; k++) begin
      ext_raise = 16'($urandom & $urandom & $urandom);
      ext_lower = 16'($urandom & $urandom);
      soft_vec  = 17'($urandom & $urandom & $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) cur_pil = 4'($urandom);
      int_en    = ($urandom_range(0, 9) != 0);
      trap_lvl  = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      tt_active = 9'($urandom_range(9'h038, 9'h058));
      cyc("R11 random");
    end
    summary();
  end
endmodule